// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block decides when a small 8-bit core should enter an interrupt service routine. It watches three request sources: one active-low external pin and two overflow pulses from timer/event counters. Each source has a pending flag and an enable bit. These flags and enables sit, together with a global enable, in one 8-bit control register. The CPU reads and writes that register at a fixed data address.

When a request is pending, enabled and globally allowed, and the return stack has room, the block emits a one-cycle take strobe with the program address of the service routine. At that moment it clears the serviced flag and the global enable. Further entries therefore stay blocked until the routine returns. A return-from-interrupt pulse sets the global enable again.

While the core is halted, any enabled pending flag raises a wake request. This happens even when the global enable is off. Only the program counter is saved by the core on entry. The status register is never saved by this block or by the sequencer.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, and `take_o` and `wake_o` are 0.
- R2: A high-to-low transition of `irq_pin_n` sets the external flag (register bit 4). It does so on the third rising edge after the pin is first sampled low, because of a two-flop synchroniser. A rising edge, or a pin held low, sets nothing.
- R3: A one-cycle pulse on `tmr_ovf_i[0]` sets bit 5, and a pulse on `tmr_ovf_i[1]` sets bit 6, at that clock edge.
- R4: The register is at address `CTL_ADDR` (default 0x0B). Bit 0 is the global enable. Bits 1, 2 and 3 enable the external, timer 0 and timer 1 sources. Bits 4, 5 and 6 are their flags. Bit 7 always reads 0. `rd_data_o` shows the addressed register one cycle after `addr_i`. Any other address reads 0x00.
- R5: `take_o` pulses for one cycle, one edge after the global enable, a source enable and its flag are all 1 while `stack_full_i` is 0. `vec_o` then carries 0x004 for the external source, 0x008 for timer 0 or 0x00C for timer 1.
- R6: The edge that raises `take_o` clears the serviced flag and the global enable.
- R7: A request that arrives while the global enable is 0 still sets its flag. It is taken once the enable is written to 1.
- R8: No request is taken while `stack_full_i` is 1. The pending request is taken on the first edge after `stack_full_i` returns to 0.
- R9: When several enabled requests are pending, the external source is served first, then timer 0, then timer 1.
- R10: A one-cycle pulse on `reti_i` sets the global enable.
- R11: While `halt_i` is 1, `wake_o` is 1 one edge after any flag whose source enable is set is pending, whatever the global enable. When `halt_i` is 0, `wake_o` is 0.
- R12: A flag whose source enable is 0 is recorded but never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Asynchronous external request pin, active on its falling edge |
| tmr_ovf_i | input | 2 | One-cycle overflow pulses of timer 0 (bit 0) and timer 1 (bit 1) |
| addr_i | input | 8 | Data address for register read and write |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| stack_full_i | input | 1 | Return stack has no free level |
| reti_i | input | 1 | Return-from-interrupt pulse |
| halt_i | input | 1 | Core is in the halt state |
| take_o | output | 1 | One-cycle strobe: enter the service routine now |
| vec_o | output | 12 | Service routine address, valid with `take_o` |
| wake_o | output | 1 | Wake request for a halted core |

## Verification
Each result has a fixed latency, and every check samples exactly there, at the falling clock edge.

| Result | Due after the stimulus edge |
|---|---|
| Timer flag | Visible at once |
| External flag | Two further edges, for the synchroniser |
| Read data | One edge after the address |
| Take strobe | One edge after its conditions hold |
| Wake | One edge after the flag |

Each expected vector is pushed into a queue before the stimulus that should cause it. A monitor pops the queue whenever the strobe is seen, so a take that is missing, extra or out of priority order is caught. The release from a full stack is checked at the exact cycle.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Source order is also the service priority (lowest index first).
  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_TMR0 = 2'd1,
    SRC_TMR1 = 2'd2
  } irq_src_e;

  localparam int VEC_SPACING = 4;

  // Service routine address for a given source index.
  function automatic logic [15:0] vector_of(input int idx);
    return 16'((idx + 1) * VEC_SPACING);
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall_o
);

  // sh[0..STAGES-1] synchronise, sh[STAGES] holds the previous synced level.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1;
    end else begin
      sh <= {sh[STAGES-1:0], pin_n};
    end
  end

  assign fall_o = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int NSRC   = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   flag_set,
  input  logic [NSRC-1:0]   flag_clr,
  input  logic              gie_set,
  input  logic              gie_clr,
  output logic              gie,
  output logic [NSRC-1:0]   src_en,
  output logic [NSRC-1:0]   flags,
  output logic [DATA_W-1:0] reg_q
);

  localparam int GIE_BIT  = 0;
  localparam int EN_LO    = 1;
  localparam int FLAG_LO  = EN_LO + NSRC;
  localparam int USED     = FLAG_LO + NSRC;
  localparam logic [DATA_W-1:0] USED_MASK = DATA_W'((1 << USED) - 1);

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = reg_q;
    if (wr_en) nxt = wdata & USED_MASK;
    nxt[FLAG_LO +: NSRC] = nxt[FLAG_LO +: NSRC] | flag_set;
    if (gie_set) nxt[GIE_BIT] = 1'b1;
    if (gie_clr) nxt[GIE_BIT] = 1'b0;
    nxt[FLAG_LO +: NSRC] = nxt[FLAG_LO +: NSRC] & ~flag_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= '0;
    else     reg_q <= nxt;
  end

  assign gie    = reg_q[GIE_BIT];
  assign src_en = reg_q[EN_LO +: NSRC];
  assign flags  = reg_q[FLAG_LO +: NSRC];

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_vec_pkg::*;
#(
  parameter int NSRC  = 3,
  parameter int VEC_W = 12
) (
  input  logic [NSRC-1:0]  req,
  output logic             any_o,
  output logic [NSRC-1:0]  sel_o,
  output logic [VEC_W-1:0] vec_o
);

  always_comb begin
    sel_o = '0;
    vec_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        sel_o = '0;
        sel_o[i] = 1'b1;
        vec_o = VEC_W'(vector_of(i));
      end
    end
  end

  assign any_o = |req;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          N_TMR       = 2,
  parameter int          DATA_W      = 8,
  parameter int          ADDR_W      = 8,
  parameter int          VEC_W       = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CTL_ADDR    = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pin_n,
  input  logic [N_TMR-1:0]  tmr_ovf_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              stack_full_i,
  input  logic              reti_i,
  input  logic              halt_i,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              wake_o
);

  localparam int NSRC = 1 + N_TMR;

  logic              ext_fall;
  logic [NSRC-1:0]   flag_set;
  logic [NSRC-1:0]   flag_clr;
  logic              gie;
  logic [NSRC-1:0]   src_en;
  logic [NSRC-1:0]   flags;
  logic [DATA_W-1:0] ctl_q;
  logic [NSRC-1:0]   cand;
  logic              cand_any;
  logic [NSRC-1:0]   cand_sel;
  logic [VEC_W-1:0]  cand_vec;
  logic              fire;
  logic              sel_hit;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_n  (irq_pin_n),
    .fall_o (ext_fall)
  );

  assign flag_set = {tmr_ovf_i, ext_fall};
  assign cand     = flags & src_en;
  assign fire     = gie & cand_any & ~stack_full_i;
  assign flag_clr = fire ? cand_sel : '0;
  assign sel_hit  = (addr_i == ADDR_W'(CTL_ADDR));

  irq_ctl_reg #(.NSRC(NSRC), .DATA_W(DATA_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en_i & sel_hit),
    .wdata    (wr_data_i),
    .flag_set (flag_set),
    .flag_clr (flag_clr),
    .gie_set  (reti_i),
    .gie_clr  (fire),
    .gie      (gie),
    .src_en   (src_en),
    .flags    (flags),
    .reg_q    (ctl_q)
  );

  irq_pick #(.NSRC(NSRC), .VEC_W(VEC_W)) u_pick (
    .req   (cand),
    .any_o (cand_any),
    .sel_o (cand_sel),
    .vec_o (cand_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o    <= 1'b0;
      vec_o     <= '0;
      wake_o    <= 1'b0;
      rd_data_o <= '0;
    end else begin
      take_o    <= fire;
      if (fire) vec_o <= cand_vec;
      wake_o    <= halt_i & cand_any;
      rd_data_o <= sel_hit ? ctl_q : '0;
    end
  end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NSRC   = 3,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              take,
  input logic [VEC_W-1:0]  vec,
  input logic              stack_full,
  input logic              halted,
  input logic              wake,
  input logic [DATA_W-1:0] ctl
);

  localparam int EN_LO   = 1;
  localparam int FLAG_LO = EN_LO + NSRC;

  // R8: no entry while the stack had no room
  p_hold_full_r8: assert property (@(posedge clk) disable iff (rst)
    take |-> !$past(stack_full));

  // R5: entry only with the global enable set
  p_need_gie_r5: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(ctl[0]));

  // R6: entry drops the global enable
  p_gie_drop_r6: assert property (@(posedge clk) disable iff (rst)
    take |-> !ctl[0]);

  // R5: one-cycle strobe with a legal vector
  p_vec_legal_r5: assert property (@(posedge clk) disable iff (rst)
    take |-> (vec == VEC_W'(4) || vec == VEC_W'(8) || vec == VEC_W'(12)));

  p_single_r5: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

  // R9: an enabled external request is never passed over
  p_prio_r9: assert property (@(posedge clk) disable iff (rst)
    (take && vec != VEC_W'(4)) |-> !($past(ctl[FLAG_LO]) && $past(ctl[EN_LO])));

  // R11: halted core with an enabled pending flag gets a wake request
  p_wake_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(halted) && $past(|(ctl[FLAG_LO +: NSRC] & ctl[EN_LO +: NSRC]))) |-> wake);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NSRC(1 + N_TMR), .DATA_W(DATA_W), .VEC_W(VEC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .take       (take_o),
  .vec        (vec_o),
  .stack_full (stack_full_i),
  .halted     (halt_i),
  .wake       (wake_o),
  .ctl        (ctl_q)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_n = 1'b1;
  logic [1:0]  tmr = 2'b00;
  logic [7:0]  addr = 8'h00;
  logic        wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        sfull = 1'b0;
  logic        reti = 1'b0;
  logic        halt = 1'b0;
  logic        take;
  logic [11:0] vec;
  logic        wake;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst(rst), .irq_pin_n(pin_n), .tmr_ovf_i(tmr),
    .addr_i(addr), .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rdata),
    .stack_full_i(sfull), .reti_i(reti), .halt_i(halt),
    .take_o(take), .vec_o(vec), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every take strobe must match the oldest expected vector.
  always @(negedge clk) begin
    if (!rst && take) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected take", {20'd0, vec}, 32'd0);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk(vec == e, "R5/R9 vector", {20'd0, vec}, {20'd0, e});
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    chk(rdata == exp, tag, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic pulse_tmr(input logic [1:0] m);
    @(negedge clk);
    tmr = m;
    @(negedge clk);
    tmr = 2'b00;
  endtask

  task automatic pulse_reti();
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(take == 1'b0, "R1 take", {31'd0, take}, 0);
    chk(wake == 1'b0, "R1 wake", {31'd0, wake}, 0);
    rd_chk(8'h0B, 8'h00, "R1 reg");

    // R4 layout, bit 7 masked, other address reads zero
    wr_reg(8'h0B, 8'h8E);
    rd_chk(8'h0B, 8'h0E, "R4 readback");
    rd_chk(8'h0A, 8'h00, "R4 other addr");

    // R3 and R7: timer 0 flag while globally disabled, no take
    pulse_tmr(2'b01);
    idle(3);
    rd_chk(8'h0B, 8'h2E, "R3 R7 flag kept");
    exp_q.push_back(12'h008);
    wr_reg(8'h0B, 8'h2F);
    idle(3);
    // R6 flag and gie cleared
    rd_chk(8'h0B, 8'h0E, "R6 cleared");

    // R2 falling edge sets external flag
    @(negedge clk); pin_n = 1'b0;
    idle(4);
    rd_chk(8'h0B, 8'h1E, "R2 fall");
    wr_reg(8'h0B, 8'h0E);
    @(negedge clk); pin_n = 1'b1;
    idle(4);
    rd_chk(8'h0B, 8'h0E, "R2 rise ignored");

    // R9 priority and R10 reti
    @(negedge clk); pin_n = 1'b0; tmr = 2'b11;
    @(negedge clk); tmr = 2'b00;
    idle(3);
    rd_chk(8'h0B, 8'h7E, "R9 all pending");
    exp_q.push_back(12'h004);
    wr_reg(8'h0B, 8'h7F);
    idle(2);
    rd_chk(8'h0B, 8'h6E, "R9 ext first");
    exp_q.push_back(12'h008);
    pulse_reti();
    idle(2);
    rd_chk(8'h0B, 8'h4E, "R10 R9 timer0 next");
    exp_q.push_back(12'h00C);
    pulse_reti();
    idle(2);
    rd_chk(8'h0B, 8'h0E, "R10 timer1 last");
    @(negedge clk); pin_n = 1'b1;
    idle(3);

    // R8 stack full holds off
    @(negedge clk); sfull = 1'b1;
    wr_reg(8'h0B, 8'h0F);
    pulse_tmr(2'b10);
    idle(5);
    rd_chk(8'h0B, 8'h4F, "R8 held");
    exp_q.push_back(12'h00C);
    sfull = 1'b0;
    @(negedge clk);
    chk(take == 1'b1, "R8 release timing", {31'd0, take}, 1);
    idle(2);
    rd_chk(8'h0B, 8'h0E, "R8 after take");

    // R12 disabled source recorded but not taken
    wr_reg(8'h0B, 8'h0B);
    pulse_tmr(2'b01);
    idle(5);
    rd_chk(8'h0B, 8'h2B, "R12 not taken");
    wr_reg(8'h0B, 8'h00);

    // R11 wake while halted, gie off
    @(negedge clk); halt = 1'b1;
    wr_reg(8'h0B, 8'h04);
    idle(2);
    chk(wake == 1'b0, "R11 no flag", {31'd0, wake}, 0);
    pulse_tmr(2'b01);
    @(negedge clk);
    chk(wake == 1'b1, "R11 wake", {31'd0, wake}, 1);
    halt = 1'b0;
    @(negedge clk);
    chk(wake == 1'b0, "R11 not halted", {31'd0, wake}, 0);

    idle(3);
    chk(exp_q.size() == 0, "R5 missing take", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule